// File: doc/BRIEF.md
# Descriptor-Chained Audio DMA Engine

This block is a single-channel bus master that moves audio sample words between system memory and a codec-side FIFO. Software places a chain of region descriptors in memory, writes the address of the first one into the table pointer register and sets the enable bit. The engine fetches each descriptor, transfers the region it describes one 32-bit word at a time and then moves on to the next descriptor. Each descriptor is two 32-bit words. Word 0 is the physical base address of the region. Word 1 carries the byte count in bits 15:0, a jump flag in bit 29, an end-of-page flag in bit 30 and an end-of-table flag in bit 31. Bits 28:16 are reserved.

The direction bit selects the transfer. With the bit clear, the engine reads words from memory and pushes them into the codec FIFO. With the bit set, it pops words from the codec FIFO and writes them to memory. A region that ends with the end-of-page flag raises a status bit and the interrupt. If a second such region completes before software has read the status register, the engine raises an overrun bit and holds still until that read. A jump descriptor redirects the table walk and moves no data. The end-of-table flag ends the walk.

The register port decodes three locations: 0 is the command register, 1 is the table pointer and 2 is the status register. Read data is combinational in the cycle of `reg_rd`. A read of location 2 clears the status at that clock edge. The memory port holds a request until `mem_ack` is high in the same cycle, and read data is taken in that cycle.

Top module: `adma_engine`

## Requirements
- R1: After reset, all three registers read zero, `irq` and `done` are low, and no memory request or FIFO handshake is active.
- R2: The table pointer always reads back with bits 1:0 at zero. A write to it is accepted only while the engine is idle or done, and is ignored while a table walk is in progress or paused.
- R3: The command register stores only bit 0 (enable) and bit 3 (direction). All other bits read as zero. A write with bit 0 set, made while the engine is idle or done and the overrun bit is clear, starts a table walk at the pointer. A write with bit 0 clear starts nothing.
- R4: The engine fetches a descriptor as two memory reads, first at the pointer and then at the pointer plus 4. After each fetch the pointer advances by 8, so a register read returns the address of the next descriptor. A request is held with a stable address until it is acknowledged.
- R5: With direction 0, the engine reads words from consecutive addresses starting at the region base and pushes them into the FIFO in order. The region contributes ceil(count/4) words, so a count of 6 gives two words.
- R6: With direction 1, the engine pops words from the FIFO and writes them, in order, to consecutive addresses starting at the region base.
- R7: A byte count of zero is treated as 65536 bytes, which is 16384 words.
- R8: A descriptor with bit 29 set loads its word 0 into the pointer as the next descriptor address and transfers no data.
- R9: Finishing a region whose bit 30 is set sets status bit 0. A read of the status register returns bits {overrun, page} in bits 1:0 and clears both. `irq` is high while either bit is set. A set in the same cycle as a clearing read wins.
- R10: Finishing an end-of-page region while status bit 0 is still set instead sets status bit 1 and pauses the engine, with no memory or FIFO traffic. The engine resumes at the next descriptor only after the status register is read.
- R11: After the region with bit 31 set completes, `done` goes high and the engine issues no further requests until it is started again.
- R12: Writing the command register with bit 0 clear returns the engine to idle from any state. `done` goes low and all traffic stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears the status) |
| reg_addr | input | 2 | Register select: 0 command, 1 pointer, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| out_valid | output | 1 | Word offered to the codec FIFO |
| out_data | output | 32 | Word for the codec FIFO |
| out_ready | input | 1 | Codec FIFO accepts the word |
| in_valid | input | 1 | Codec FIFO has a word for memory |
| in_data | input | 32 | Word from the codec FIFO |
| in_ready | output | 1 | Engine takes the word |
| irq | output | 1 | Interrupt, high while any status bit is set |
| done | output | 1 | End of table reached |

## Verification
The bench walks tables that exercise a byte count that is not a multiple of four, a zero count that must turn into a full 64 KiB region, and a jump entry. A design that rounds the count down would drop the last word. One that takes zero literally would finish at once. One that moves data for the jump entry would push stray words into the scoreboard. Two end-of-page regions in a row without a status read must leave the engine frozen, with the pointer locked against writes, until the read returns the overrun code. A design that kept going or lost the set would show it as a missing pause or as leftover queued words. Random back-pressure on the memory grant and on both FIFO sides tests that requests hold steady and that words arrive in order. Abort and start refusal are checked through the command readback and the idle outputs.

// File: rtl/adma_pkg.sv
package adma_pkg;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned FLAG_END   = 31;
    localparam int unsigned FLAG_PAGE  = 30;
    localparam int unsigned FLAG_JUMP  = 29;

    localparam logic [1:0] RA_CMD = 2'd0;
    localparam logic [1:0] RA_PTR = 2'd1;
    localparam logic [1:0] RA_STS = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH0,
        S_FETCH1,
        S_RD,
        S_PUSH,
        S_POP,
        S_WR,
        S_END,
        S_PAUSE,
        S_DONE
    } state_e;

    typedef struct packed {
        state_e      st;
        logic        en;
        logic        dir;
        logic [29:0] ptr;
        logic [29:0] cur;
        logic        page;
        logic        last_tbl;
        logic [31:0] data;
    } core_t;

endpackage

// File: rtl/adma_desc_decode.sv
module adma_desc_decode #(
    parameter int unsigned CNT_W = 16
) (
    input  logic [31:0]    ctl_word,
    output logic           end_flag,
    output logic           page_flag,
    output logic           jump_flag,
    output logic [CNT_W:0] bytes
);
    import adma_pkg::*;

    logic unused_rsvd;
    assign unused_rsvd = ^ctl_word[28:CNT_W];

    always_comb begin
        end_flag  = ctl_word[FLAG_END];
        page_flag = ctl_word[FLAG_PAGE];
        jump_flag = ctl_word[FLAG_JUMP];
        if (ctl_word[CNT_W-1:0] == '0) begin
            bytes = {1'b1, {CNT_W{1'b0}}};
        end else begin
            bytes = {1'b0, ctl_word[CNT_W-1:0]};
        end
    end
endmodule

// File: rtl/adma_region_ctr.sv
module adma_region_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [CNT_W:0] load_bytes,
    input  logic           step,
    output logic           last
);
    import adma_pkg::*;

    localparam int unsigned REM_W = CNT_W + 1;
    localparam logic [REM_W-1:0] STEP_V = REM_W'(WORD_BYTES);

    logic [REM_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load) begin
            rem_d = load_bytes;
        end else if (step) begin
            rem_d = (rem_q > STEP_V) ? (rem_q - STEP_V) : '0;
        end
        last = (rem_q <= STEP_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end
endmodule

// File: rtl/adma_status.sv
module adma_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_page,
    input  logic       set_over,
    input  logic       clr,
    output logic [1:0] bits,
    output logic       irq
);
    logic [1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (clr) begin
            bits_d = 2'b00;
        end
        if (set_page) begin
            bits_d[0] = 1'b1;
        end
        if (set_over) begin
            bits_d[1] = 1'b1;
        end
        bits = bits_q;
        irq  = |bits_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= 2'b00;
        end else begin
            bits_q <= bits_d;
        end
    end
endmodule

// File: rtl/adma_engine.sv
module adma_engine #(
    parameter int unsigned CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        out_valid,
    output logic [31:0] out_data,
    input  logic        out_ready,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        irq,
    output logic        done
);
    import adma_pkg::*;

    localparam int unsigned BYTES_W = CNT_W + 1;

    core_t q, n;

    logic               dec_end, dec_page, dec_jump;
    logic [BYTES_W-1:0] dec_bytes;
    logic               ctr_load, ctr_step, ctr_last;
    logic               set_page, set_over, sts_rd;
    logic [1:0]         sts_bits;
    logic               startable;

    logic unused_bits;
    assign unused_bits = reg_wdata[1];

    adma_desc_decode #(.CNT_W(CNT_W)) u_dec (
        .ctl_word  (mem_rdata),
        .end_flag  (dec_end),
        .page_flag (dec_page),
        .jump_flag (dec_jump),
        .bytes     (dec_bytes)
    );

    adma_region_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ctr_load),
        .load_bytes (dec_bytes),
        .step       (ctr_step),
        .last       (ctr_last)
    );

    adma_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_page (set_page),
        .set_over (set_over),
        .clr      (sts_rd),
        .bits     (sts_bits),
        .irq      (irq)
    );

    always_comb begin
        n         = q;
        set_page  = 1'b0;
        set_over  = 1'b0;
        ctr_load  = 1'b0;
        ctr_step  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        out_valid = 1'b0;
        out_data  = q.data;
        in_ready  = 1'b0;
        sts_rd    = reg_rd && (reg_addr == RA_STS);
        startable = (q.st == S_IDLE) || (q.st == S_DONE);

        case (q.st)
            S_FETCH0: begin
                mem_req  = 1'b1;
                mem_addr = {q.ptr, 2'b00};
                if (mem_ack) begin
                    n.cur = mem_rdata[31:2];
                    n.st  = S_FETCH1;
                end
            end
            S_FETCH1: begin
                mem_req  = 1'b1;
                mem_addr = {q.ptr + 30'd1, 2'b00};
                if (mem_ack) begin
                    if (dec_jump) begin
                        n.ptr = q.cur;
                        n.st  = S_FETCH0;
                    end else begin
                        n.ptr      = q.ptr + 30'd2;
                        ctr_load   = 1'b1;
                        n.page     = dec_page;
                        n.last_tbl = dec_end;
                        n.st       = q.dir ? S_POP : S_RD;
                    end
                end
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = {q.cur, 2'b00};
                if (mem_ack) begin
                    n.data = mem_rdata;
                    n.st   = S_PUSH;
                end
            end
            S_PUSH: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    ctr_step = 1'b1;
                    n.cur    = q.cur + 30'd1;
                    n.st     = ctr_last ? S_END : S_RD;
                end
            end
            S_POP: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    n.data = in_data;
                    n.st   = S_WR;
                end
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {q.cur, 2'b00};
                mem_wdata = q.data;
                if (mem_ack) begin
                    ctr_step = 1'b1;
                    n.cur    = q.cur + 30'd1;
                    n.st     = ctr_last ? S_END : S_POP;
                end
            end
            S_END: begin
                if (q.page && sts_bits[0] && !sts_rd) begin
                    set_over = 1'b1;
                    n.st     = S_PAUSE;
                end else begin
                    set_page = q.page;
                    n.st     = q.last_tbl ? S_DONE : S_FETCH0;
                end
            end
            S_PAUSE: begin
                if (sts_rd) begin
                    n.st = q.last_tbl ? S_DONE : S_FETCH0;
                end
            end
            default: begin
            end
        endcase

        if (reg_wr && (reg_addr == RA_PTR) && startable) begin
            n.ptr = reg_wdata[31:2];
        end
        if (reg_wr && (reg_addr == RA_CMD)) begin
            n.en  = reg_wdata[0];
            n.dir = reg_wdata[3];
            if (!reg_wdata[0]) begin
                n.st = S_IDLE;
            end else if (startable && !sts_bits[1]) begin
                n.st = S_FETCH0;
            end
        end

        case (reg_addr)
            RA_CMD:  reg_rdata = {28'd0, q.dir, 2'b00, q.en};
            RA_PTR:  reg_rdata = {q.ptr, 2'b00};
            RA_STS:  reg_rdata = {30'd0, sts_bits};
            default: reg_rdata = '0;
        endcase

        done = (q.st == S_DONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end
endmodule

// File: rtl/adma_engine_chk.sv
module adma_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [1:0]  reg_addr,
    input logic        reg_wdata0,
    input logic [31:0] reg_rdata,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        out_valid,
    input logic        in_ready,
    input logic        done,
    input logic [1:0]  sts_bits,
    input logic        set_page,
    input logic        set_over
);
    p_ptr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (reg_rdata[1:0] == 2'b00));

    // R4: an unacknowledged request keeps its address unless aborted
    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !(reg_wr && reg_addr == 2'd0 && !reg_wdata0))
        |=> (mem_req && $stable(mem_addr)));

    p_one_mover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, out_valid, in_ready}));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2 && !set_page && !set_over) |=> (sts_bits == 2'b00));

    p_quiet_on_over_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sts_bits[1] |-> (!mem_req && !out_valid && !in_ready));

    p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && !out_valid && !in_ready));
endmodule

bind adma_engine adma_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata0 (reg_wdata[0]),
    .reg_rdata  (reg_rdata),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .out_valid  (out_valid),
    .in_ready   (in_ready),
    .done       (done),
    .sts_bits   (sts_bits),
    .set_page   (set_page),
    .set_over   (set_over)
);

// File: tb/adma_engine_test.sv
`timescale 1ns/1ps
module adma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        out_valid, out_ready, in_valid, in_ready, irq, done;
    logic [31:0] out_data, in_data;

    logic [31:0] mem [1024];
    logic [7:0]  lfsr;
    logic [31:0] src_val;
    logic        hw_en = 1'b0;
    logic [9:0]  hw_idx = '0;
    logic [31:0] hw_data = '0;
    logic        chk_push = 1'b1;

    logic [31:0] exp_push[$];
    logic [63:0] exp_wr[$];

    int n_checks = 0, n_fail = 0, mon_checks = 0, mon_fail = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    adma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .irq(irq), .done(done)
    );

    assign mem_ack   = mem_req && (lfsr[1] || lfsr[3]);
    assign mem_rdata = mem[mem_addr[11:2]];
    assign out_ready = lfsr[0] || lfsr[2];
    assign in_valid  = lfsr[4] || lfsr[6];
    assign in_data   = src_val;

    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr    <= 8'h5A;
            src_val <= 32'hA500_0000;
            for (int i = 0; i < 1024; i++) mem[i] <= 32'hC0DE_0000 + i;
        end else begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (in_valid && in_ready) src_val <= src_val + 1;
            if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
            else if (hw_en) mem[hw_idx] <= hw_data;
        end
    end

    // monitor: compares produced items against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready && chk_push) begin
                mon_checks++;
                if (exp_push.size() == 0) begin
                    mon_fail++;
                    $display("FAIL R5: unexpected FIFO word %h expected none", out_data);
                end else begin
                    logic [31:0] e;
                    e = exp_push.pop_front();
                    if (out_data !== e) begin
                        mon_fail++;
                        $display("FAIL R5: FIFO word %h expected %h", out_data, e);
                    end
                end
            end
            if (mem_req && mem_we && mem_ack) begin
                mon_checks++;
                if (exp_wr.size() == 0) begin
                    mon_fail++;
                    $display("FAIL R6: unexpected write %h:%h expected none", mem_addr, mem_wdata);
                end else begin
                    logic [63:0] e;
                    e = exp_wr.pop_front();
                    if ({mem_addr, mem_wdata} !== e) begin
                        mon_fail++;
                        $display("FAIL R6: write %h expected %h", {mem_addr, mem_wdata}, e);
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic poke(input int idx, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_idx = idx[9:0]; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    // driver: queue the words a read region must produce
    task automatic expect_region(input logic [31:0] base, input int words);
        for (int k = 0; k < words; k++) exp_push.push_back(mem[(base[11:2] + k) % 1024]);
    endtask

    task automatic wait_done(input string req, input int limit);
        int c = 0;
        while (!done && c < limit) begin @(negedge clk); c++; end
        check(req, {31'd0, done}, 32'd1);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] s0;
        int quiet;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd0, v); check("R1 cmd", v, 32'h0);
        reg_read(2'd1, v); check("R1 ptr", v, 32'h0);
        reg_read(2'd2, v); check("R1 sts", v, 32'h0);
        check("R1 outputs", {28'd0, irq, done, mem_req, out_valid}, 32'h0);

        // R2 alignment, R3 command field masking, no start
        reg_write(2'd1, 32'h0000_0103);
        reg_read(2'd1, v); check("R2 ptr low bits", v, 32'h0000_0100);
        reg_write(2'd0, 32'hFFFF_FFFE);
        reg_read(2'd0, v); check("R3 cmd readback", v, 32'h0000_0008);
        quiet = 0;
        repeat (5) begin @(negedge clk); if (mem_req) quiet++; end
        check("R3 no start", quiet, 0);
        reg_write(2'd0, 32'h0);

        // R4 R5 R9 R11: two regions, 12 bytes then 6 bytes (page+end)
        poke(64, 32'h400); poke(65, 32'h0000_000C);
        poke(66, 32'h500); poke(67, 32'hC000_0006);
        expect_region(32'h400, 3);
        expect_region(32'h500, 2);
        reg_write(2'd0, 32'h1);
        wait_done("R11 done after end", 2000);
        check("R5 all words out", exp_push.size(), 0);
        check("R9 irq on page", {31'd0, irq}, 32'd1);
        reg_read(2'd1, v); check("R4 ptr next desc", v, 32'h110);
        quiet = 0;
        repeat (10) begin @(negedge clk); if (mem_req) quiet++; end
        check("R11 idle after end", quiet, 0);
        reg_read(2'd2, v); check("R9 page bit", v, 32'h1);
        reg_read(2'd2, v); check("R9 cleared by read", v, 32'h0);
        check("R9 irq drops", {31'd0, irq}, 32'd0);

        // R8 jump entry
        poke(96, 32'h1A0); poke(97, 32'h2000_0008);
        poke(104, 32'h600); poke(105, 32'h8000_0004);
        expect_region(32'h600, 1);
        reg_write(2'd1, 32'h180);
        reg_write(2'd0, 32'h1);
        wait_done("R8 jump walk ends", 2000);
        check("R8 only target data", exp_push.size(), 0);
        reg_read(2'd1, v); check("R8 ptr after jump", v, 32'h1A8);

        // R7 zero count
        poke(128, 32'h0); poke(129, 32'h8000_0000);
        expect_region(32'h0, 16384);
        reg_write(2'd1, 32'h200);
        reg_write(2'd0, 32'h1);
        wait_done("R7 full region ends", 120000);
        check("R7 16384 words", exp_push.size(), 0);

        // R10 overrun pause
        poke(144, 32'h800); poke(145, 32'h4000_0004);
        poke(146, 32'h810); poke(147, 32'h4000_0004);
        poke(148, 32'h820); poke(149, 32'h8000_0004);
        expect_region(32'h800, 1); expect_region(32'h810, 1); expect_region(32'h820, 1);
        reg_write(2'd1, 32'h240);
        reg_write(2'd0, 32'h1);
        begin
            int c = 0;
            while (exp_push.size() > 1 && c < 2000) begin @(negedge clk); c++; end
        end
        repeat (30) @(negedge clk);
        check("R10 paused before third", exp_push.size(), 1);
        check("R10 irq held", {31'd0, irq}, 32'd1);
        quiet = 0;
        repeat (10) begin @(negedge clk); if (mem_req || out_valid || done) quiet++; end
        check("R10 no traffic", quiet, 0);
        reg_write(2'd1, 32'h0);
        reg_read(2'd1, v); check("R2 ptr write ignored", v, 32'h250);
        reg_read(2'd2, v); check("R10 overrun code", v, 32'h3);
        wait_done("R10 resumes", 2000);
        check("R10 third region", exp_push.size(), 0);
        reg_read(2'd2, v); check("R10 status after", v, 32'h0);

        // R6 write direction
        poke(160, 32'h700); poke(161, 32'h8000_000C);
        s0 = src_val;
        for (int k = 0; k < 3; k++) exp_wr.push_back({32'h700 + 32'(4 * k), s0 + 32'(k)});
        reg_write(2'd1, 32'h280);
        reg_write(2'd0, 32'h9);
        wait_done("R6 write walk ends", 2000);
        check("R6 writes seen", exp_wr.size(), 0);
        check("R6 mem word 2", mem[450], s0 + 2);

        // R12 abort mid region
        poke(176, 32'h900); poke(177, 32'h0000_0040);
        chk_push = 1'b0;
        reg_write(2'd1, 32'h2C0);
        reg_write(2'd0, 32'h1);
        repeat (10) @(negedge clk);
        reg_write(2'd0, 32'h0);
        quiet = 0;
        repeat (20) begin @(negedge clk); if (mem_req || out_valid || in_ready || done) quiet++; end
        check("R12 stops", quiet, 0);
        reg_read(2'd0, v); check("R12 cmd cleared", v, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", (n_checks - n_fail) + (mon_checks - mon_fail),
                 n_checks + mon_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", (n_checks - n_fail) + (mon_checks - mon_fail),
                     n_checks + mon_checks + 1);
            $finish;
        end
    end
endmodule